// File: doc/BRIEF.md
# Interleaving Address Range Router

This block sits at the upstream side of a memory port and decides which downstream port serves each incoming host physical address. It holds a bank of programmable decoders. Each decoder claims one contiguous address window. It sends matching requests either to one fixed port, or spreads them over 2, 4 or 8 ports. For spreading, it takes an index from the address bits just above the interleave granule.

A decoder can also sit below an upper level that has already interleaved the traffic. In that case the decoder sees only every Nth granule of the window. A per-decoder upper-ways field moves the index field up by log2 of the upper level's ways, so the two levels combine into a wider interleave. Software programs base, size, target list and control through a simple write port. A decoder joins matching only once it is enabled and committed, and it is frozen while committed.

Requests arrive on a valid/ready channel and leave on a registered valid/ready response channel one cycle later. A request is accepted on a rising clock edge where `req_valid` and `req_ready` are both high, and `req_ready` is high whenever the response register is empty or is being drained (`!rsp_valid || rsp_ready`). A response that is not taken stays unchanged until `rsp_ready` rises.

Top module: `ilv_router`

## Requirements
- R1: A request hits when some committed, enabled decoder has base <= addr < base + size (size 0 claims nothing). Otherwise the response shows `rsp_hit`=0 and `rsp_port`=0.
- R2: A decoder with ways code 0 (one way) always returns target entry 0. Target entry i sits at `cfg_wdata` bits [i*PORT_W +: PORT_W] of a target-list write.
- R3: Ways code c (bits [1:0] of the control word) gives 2^c ways. The port is target entry ((addr >> (8 + g + u)) mod 2^c), where g is the granularity code (bits [4:2], granule 256 << g bytes) and u is the upper-ways code. A granularity code above 6 is stored as 6 (16 KiB).
- R4: The upper-ways code u (control bits [6:5]) moves the index field up by u bits, so address bits below it do not affect the chosen port.
- R5: A decoder takes part in matching only when both control bit 7 (enable) and bit 8 (commit) are 1. After reset every decoder is uncommitted.
- R6: While a decoder is committed, every write to it is ignored, with one exception. A control write (select 3) with bit 8 = 0 clears commit and leaves all other fields unchanged.
- R7: When several eligible decoders match, the lowest-numbered one decides the port.
- R8: A request accepted at a clock edge produces `rsp_valid`=1 with its result right after the next rising edge.
- R9: While `rsp_valid`=1 and `rsp_ready`=0, `req_ready` is 0 and `rsp_hit`/`rsp_port` hold their values. The stalled request is accepted at the edge where `rsp_ready` returns to 1.
- R10: During and after reset `rsp_valid` is 0 and `req_ready` is 1. Until decoders are programmed, every request misses.
- R11: A request accepted at the same edge as a register write is decoded with the settings from before that write.

Write selects (`cfg_sel`): 0 base, 1 size, 2 target list, 3 control. Writes with `cfg_dec` >= NUM_DEC are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_dec | input | $clog2(NUM_DEC) | Decoder number for the write |
| cfg_sel | input | 2 | Register select: 0 base, 1 size, 2 targets, 3 control |
| cfg_wdata | input | ADDR_W | Write data |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | ADDR_W | Host physical address of the request |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | A decoder claimed the address |
| rsp_port | output | PORT_W | Selected downstream port, 0 on miss |

## Verification
Two functions can meet in one cycle: a register write that commits or uncommits a decoder, and a request whose address that decoder claims. The bench raises the write strobe and the request valid on the same falling edge. It expects that request to see the old setting (a hit while uncommitting, a miss while committing), and the very next request to see the new one. Response back-pressure also overlaps with a waiting request. The bench holds `rsp_ready` low while a second request waits, and checks that the first result stays frozen and the second arrives only after the release.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  // Smallest granule is 2**GRAN_LOG_MIN bytes
  localparam int          GRAN_LOG_MIN  = 8;
  localparam logic [2:0]  GRAN_CODE_MAX = 3'd6;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_SIZE = 2'd1,
    SEL_TGT  = 2'd2,
    SEL_CTRL = 2'd3
  } cfg_sel_e;

  // Control word, bit 8 down to bit 0
  typedef struct packed {
    logic       commit;
    logic       en;
    logic [1:0] up_code;
    logic [2:0] gran_code;
    logic [1:0] way_code;
  } dec_ctrl_t;

  localparam int CTRL_W = $bits(dec_ctrl_t);

endpackage

// File: rtl/ilv_dec_regs.sv
module ilv_dec_regs
  import ilv_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TGT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  cfg_sel_e          wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] size_o,
  output logic [TGT_W-1:0]  tgt_o,
  output dec_ctrl_t         ctrl_o
);

  logic [ADDR_W-1:0] base_q, size_q;
  logic [TGT_W-1:0]  tgt_q;
  dec_ctrl_t         ctrl_q;
  dec_ctrl_t         wr_ctrl;

  // Clamp granule code to the largest supported size
  always_comb begin
    wr_ctrl = dec_ctrl_t'(wr_data[CTRL_W-1:0]);
    if (wr_ctrl.gran_code > GRAN_CODE_MAX) wr_ctrl.gran_code = GRAN_CODE_MAX;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= '0;
      tgt_q  <= '0;
      ctrl_q <= '0;
    end else if (wr_en) begin
      if (ctrl_q.commit) begin
        // Locked: only an uncommit request gets through
        if (wr_sel == SEL_CTRL && !wr_ctrl.commit) ctrl_q.commit <= 1'b0;
      end else begin
        case (wr_sel)
          SEL_BASE: base_q <= wr_data;
          SEL_SIZE: size_q <= wr_data;
          SEL_TGT:  tgt_q  <= wr_data[TGT_W-1:0];
          SEL_CTRL: ctrl_q <= wr_ctrl;
          default:  ;
        endcase
      end
    end
  end

  assign base_o = base_q;
  assign size_o = size_q;
  assign tgt_o  = tgt_q;
  assign ctrl_o = ctrl_q;

  // R6: a committed decoder keeps every field but commit
  a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ctrl_q.commit) |=>
      ($stable(base_q) && $stable(size_q) && $stable(tgt_q) &&
       $stable(ctrl_q.en) && $stable(ctrl_q.way_code) &&
       $stable(ctrl_q.gran_code) && $stable(ctrl_q.up_code)));

  // R6: uncommit write is honoured while locked
  a_r6_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ctrl_q.commit && wr_sel == SEL_CTRL && !wr_data[CTRL_W-1]) |=>
      !ctrl_q.commit);

  // R3: stored granule never exceeds 16 KiB
  a_r3_gran_cap: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.gran_code <= GRAN_CODE_MAX);

endmodule

// File: rtl/ilv_dec_match.sv
module ilv_dec_match
  import ilv_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int PORT_W   = 3,
  parameter int MAX_WAYS = 8
) (
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [ADDR_W-1:0]          base_i,
  input  logic [ADDR_W-1:0]          size_i,
  input  logic [MAX_WAYS*PORT_W-1:0] tgt_i,
  input  dec_ctrl_t                  ctrl_i,
  output logic                       hit_o,
  output logic [PORT_W-1:0]          port_o
);

  localparam int WAY_W = $clog2(MAX_WAYS);

  logic [PORT_W-1:0] tgt_a [MAX_WAYS];
  logic [ADDR_W-1:0] offs;
  logic              in_rng;
  logic [4:0]        sh;
  logic [WAY_W-1:0]  mask, idx;

  for (genvar w = 0; w < MAX_WAYS; w++) begin : g_unpack
    assign tgt_a[w] = tgt_i[w*PORT_W +: PORT_W];
  end

  always_comb begin
    offs   = addr_i - base_i;
    in_rng = (addr_i >= base_i) && (offs < size_i);
    // Index starts above granule bits plus the upper level's ways bits
    sh     = 5'(GRAN_LOG_MIN) + {2'b00, ctrl_i.gran_code} + {3'b000, ctrl_i.up_code};
    mask   = WAY_W'((32'd1 << ctrl_i.way_code) - 32'd1);
    idx    = WAY_W'(addr_i >> sh) & mask;
    hit_o  = ctrl_i.commit && ctrl_i.en && in_rng;
    port_o = tgt_a[idx];
  end

endmodule

// File: rtl/ilv_prio_pick.sv
module ilv_prio_pick #(
  parameter int N      = 5,
  parameter int PORT_W = 3
) (
  input  logic [N-1:0]             hit_i,
  input  logic [N-1:0][PORT_W-1:0] port_i,
  output logic                     any_o,
  output logic [PORT_W-1:0]        port_o,
  output logic [N-1:0]             grant_o
);

  // Lowest index wins
  always_comb begin
    any_o   = 1'b0;
    port_o  = '0;
    grant_o = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_i[i] && !any_o) begin
        any_o      = 1'b1;
        port_o     = port_i[i];
        grant_o[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/ilv_router.sv
module ilv_router
  import ilv_pkg::*;
#(
  parameter int NUM_DEC  = 5,
  parameter int ADDR_W   = 32,
  parameter int PORT_W   = 3,
  parameter int MAX_WAYS = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [$clog2(NUM_DEC)-1:0] cfg_dec,
  input  logic [1:0]                 cfg_sel,
  input  logic [ADDR_W-1:0]          cfg_wdata,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [ADDR_W-1:0]          req_addr,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic                       rsp_hit,
  output logic [PORT_W-1:0]          rsp_port
);

  localparam int TGT_W = MAX_WAYS * PORT_W;
  localparam int DEC_W = $clog2(NUM_DEC);

  logic [ADDR_W-1:0]              d_base [NUM_DEC];
  logic [ADDR_W-1:0]              d_size [NUM_DEC];
  logic [TGT_W-1:0]               d_tgt  [NUM_DEC];
  dec_ctrl_t                      d_ctrl [NUM_DEC];
  logic [NUM_DEC-1:0]             d_hit;
  logic [NUM_DEC-1:0][PORT_W-1:0] d_port;
  logic [NUM_DEC-1:0]             grant;
  logic                           any_hit;
  logic [PORT_W-1:0]              pick_port;

  for (genvar d = 0; d < NUM_DEC; d++) begin : g_dec
    ilv_dec_regs #(.ADDR_W(ADDR_W), .TGT_W(TGT_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we && cfg_dec == DEC_W'(d)),
      .wr_sel  (cfg_sel_e'(cfg_sel)),
      .wr_data (cfg_wdata),
      .base_o  (d_base[d]),
      .size_o  (d_size[d]),
      .tgt_o   (d_tgt[d]),
      .ctrl_o  (d_ctrl[d])
    );

    ilv_dec_match #(.ADDR_W(ADDR_W), .PORT_W(PORT_W), .MAX_WAYS(MAX_WAYS)) u_match (
      .addr_i (req_addr),
      .base_i (d_base[d]),
      .size_i (d_size[d]),
      .tgt_i  (d_tgt[d]),
      .ctrl_i (d_ctrl[d]),
      .hit_o  (d_hit[d]),
      .port_o (d_port[d])
    );

    // R5: only an enabled, committed decoder can win
    a_r5_eligible: assert property (@(posedge clk) disable iff (!rst_n)
      grant[d] |-> (d_ctrl[d].commit && d_ctrl[d].en));

    // R7: no lower-numbered decoder also matched
    a_r7_lowest: assert property (@(posedge clk) disable iff (!rst_n)
      grant[d] |-> ((d_hit & NUM_DEC'((1 << d) - 1)) == '0));
  end

  ilv_prio_pick #(.N(NUM_DEC), .PORT_W(PORT_W)) u_pick (
    .hit_i   (d_hit),
    .port_i  (d_port),
    .any_o   (any_hit),
    .port_o  (pick_port),
    .grant_o (grant)
  );

  // Response register with pass-through ready
  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_port  <= '0;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit  <= any_hit;
        rsp_port <= any_hit ? pick_port : '0;
      end
    end
  end

  a_r7_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) && $stable(rsp_port)));

  a_r1_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_port == '0));

endmodule

// File: tb/sim_ilv_router.sv
module sim_ilv_router;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_dec = '0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_hit;
  logic [2:0]  rsp_port;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  ilv_router u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dec(cfg_dec),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_port(rsp_port)
  );

  // {addr, expected hit, expected port}
  localparam logic [39:0] VEC [15] = '{
    {32'h1000_0000, 4'h1, 4'h5},  // R1 base edge, R2 single way
    {32'h10FF_FFFF, 4'h1, 4'h5},  // R1 last byte
    {32'h0FFF_FFFF, 4'h0, 4'h0},  // R1 below every window
    {32'h1090_0000, 4'h1, 4'h5},  // R7 overlap, decoder 0 wins
    {32'h1100_0000, 4'h1, 4'h7},  // R1 end exclusive, decoder 3 alone
    {32'h2000_0000, 4'h1, 4'h1},  // R3 two ways, 8 KiB
    {32'h2000_2000, 4'h1, 4'h2},
    {32'h2000_4000, 4'h1, 4'h1},
    {32'h3000_0000, 4'h1, 4'h3},  // R4 four ways above an upper 2-way
    {32'h3000_0200, 4'h1, 4'h4},
    {32'h3000_0400, 4'h1, 4'h6},
    {32'h3000_0600, 4'h1, 4'h7},
    {32'h3000_0100, 4'h1, 4'h3},  // R4 bit below shifted field ignored
    {32'h4000_0000, 4'h0, 4'h0},  // R5 decoder 4 still uncommitted
    {32'h2100_0000, 4'h0, 4'h0}   // R1 end of decoder 1
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int d, input int sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_dec = 3'(d); cfg_sel = 2'(sel); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // One request; result sampled one cycle after acceptance
  task automatic req(input logic [31:0] a, input string tag,
                     input logic exp_hit, input logic [2:0] exp_port);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R8 valid"}, 32'(rsp_valid), 32'd1);
    check({tag, " hit"}, 32'(rsp_hit), 32'(exp_hit));
    check({tag, " port"}, 32'(rsp_port), 32'(exp_port));
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] tl;
    repeat (3) @(negedge clk);
    check("R10 rsp_valid in reset", 32'(rsp_valid), 32'd0);
    check("R10 req_ready in reset", 32'(req_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    req(32'h1000_0000, "R10 blank miss", 1'b0, 3'd0);

    // Program decoders 0..3
    wr(0, 0, 32'h1000_0000); wr(0, 1, 32'h0100_0000); wr(0, 2, 32'h5);   wr(0, 3, 32'h180);
    wr(1, 0, 32'h2000_0000); wr(1, 1, 32'h0100_0000); wr(1, 2, 32'h11);  wr(1, 3, 32'h195);
    wr(2, 0, 32'h3000_0000); wr(2, 1, 32'h0100_0000); wr(2, 2, 32'hFA3); wr(2, 3, 32'h1A2);
    wr(3, 0, 32'h1080_0000); wr(3, 1, 32'h0100_0000); wr(3, 2, 32'h7);   wr(3, 3, 32'h180);

    for (int i = 0; i < 15; i++) begin
      req(VEC[i][39:8], $sformatf("R1/R3 vec%0d", i), VEC[i][4], VEC[i][2:0]);
    end

    // R5 and R3: eight ways, granule code 7 clamps to 16 KiB
    tl = '0;
    for (int i = 0; i < 8; i++) tl = tl | (32'(i) << (3 * i));
    wr(4, 0, 32'h4000_0000); wr(4, 1, 32'h0010_0000); wr(4, 2, tl);
    wr(4, 3, 32'h11F);                       // commit, not enabled
    req(32'h4001_4000, "R5 disabled", 1'b0, 3'd0);
    wr(4, 3, 32'h000);                       // R6 uncommit
    wr(4, 3, 32'h19F);
    req(32'h4001_4000, "R3 eight way clamp", 1'b1, 3'd5);
    req(32'h4001_C000, "R3 eight way top", 1'b1, 3'd7);

    // R6: writes to committed decoder 0 are dropped
    wr(0, 0, 32'h5000_0000);
    wr(0, 3, 32'h100);                       // commit kept, enable 0 ignored
    req(32'h1000_0000, "R6 base kept", 1'b1, 3'd5);
    req(32'h5000_0000, "R6 new base unused", 1'b0, 3'd0);

    // R11: uncommit in the same cycle as a request
    @(negedge clk);
    cfg_we = 1'b1; cfg_dec = 3'd0; cfg_sel = 2'd3; cfg_wdata = 32'h0;
    req_valid = 1'b1; req_addr = 32'h1000_0000;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    check("R11 old commit hit", 32'(rsp_hit), 32'd1);
    check("R11 old commit port", 32'(rsp_port), 32'd5);
    req(32'h1000_0000, "R11 after uncommit", 1'b0, 3'd0);

    // R11: commit in the same cycle as a request
    @(negedge clk);
    cfg_we = 1'b1; cfg_dec = 3'd0; cfg_sel = 2'd3; cfg_wdata = 32'h180;
    req_valid = 1'b1; req_addr = 32'h1000_0000;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    check("R11 pre-commit miss", 32'(rsp_hit), 32'd0);
    req(32'h1000_0000, "R11 after commit", 1'b1, 3'd5);

    // R9: back-pressure
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_addr = 32'h2000_2000;
    @(negedge clk);
    req_addr = 32'h1000_0000;
    check("R9 first port", 32'(rsp_port), 32'd2);
    check("R9 ready low", 32'(req_ready), 32'd0);
    repeat (2) @(negedge clk);
    check("R9 held valid", 32'(rsp_valid), 32'd1);
    check("R9 held port", 32'(rsp_port), 32'd2);
    check("R9 held hit", 32'(rsp_hit), 32'd1);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 second port", 32'(rsp_port), 32'd5);
    check("R9 second valid", 32'(rsp_valid), 32'd1);
    @(negedge clk);
    check("R9 drained", 32'(rsp_valid), 32'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule